// File: doc/BRIEF.md
# Lifecycle Transition Sequencer

This block is the control state machine that carries one requested lifecycle-state change through an ordered series of steps. Once a transition is requested from the idle state, the machine switches the clock source and then issues work, one step at a time, to external stub units: counter increment, counter programming, validity check, token hashing, an optional RMA flash step, a two-phase token comparison and the final state programming. Each step either succeeds and moves the chain forward, or reports an error and drops the machine into the post-transition state. Errors are recorded in a sticky flag that is read together with the final acknowledge.

All step units share one plain handshake. On the first cycle of each step state the block raises `step_req_o` for one cycle and presents the step number on `step_id_o`. It then waits in that state until the responder raises `step_done_i`, with `step_err_i` marking a failure. Two independent escalation inputs override every state and lock the machine in a terminal escalation state. An idle-only scrap request leads to a separate terminal state. The state register uses sparse 16-bit codes, so any corrupted value decodes as invalid and escalates.

Top module: `lct_sequencer`

## Requirements
- R1: While `rst_ni` is low, `state_o` reads 0 (reset), and `step_req_o`, `trans_ack_o`, `trans_err_o`, `scrapped_o` and `escalated_o` are low. The first rising edge after reset is released moves `state_o` to 1 (idle).
- R2: `state_o` encodes the states as: reset 0, idle 1, clock switch 2, counter increment 3, counter program 4, validity check 5, token hash 6, RMA flash 7, token compare 0 8, token compare 1 9, state program 10, post-transition 11, scrap 12, escalate 13, invalid 14. A `trans_req_i` seen in idle leads to the clock switch state for exactly one cycle and then to counter increment. `step_req_o` is high for exactly the first cycle of each step state (3 to 10), and `step_id_o` then equals the state number minus 3.
- R3: A step state holds, with no further `step_req_o` pulse, for as long as `step_done_i` stays low.
- R4: A done with error in counter increment, counter program, validity check, token hash, token compare 0 or token compare 1 moves the machine to post-transition on the next edge. Any done with error in a step state sets `trans_err_o`, which stays high until reset.
- R5: On a successful step the chain advances in this order: counter increment, counter program, validity check, token hash. After token hash it goes to RMA flash if `trans_rma_i` was high when the request was accepted, and otherwise to state program. RMA flash always proceeds to token compare 0. Compare 0 leads to compare 1, and compare 1 leads to state program. State program always ends in post-transition, whatever its error bit.
- R6: In post-transition, `trans_ack_o` is high. The state is left only by reset or escalation, and new requests are ignored.
- R7: A `scrap_req_i` in idle moves the machine to scrap and takes priority over a simultaneous `trans_req_i`. Scrap sets `scrapped_o` and ignores later requests.
- R8: If either `esc_a_i` or `esc_b_i` is high at an edge, the next state is escalate, from any state. Escalate sets `escalated_o` and holds after both inputs drop.
- R9: A state-register value that is not one of the legal codes shows as invalid (14), for example the idle code 16'h33C3 with bit 5 flipped. Invalid moves to escalate on the next edge.
- R10: The legal codes are 16 bits wide and all have even parity, so a single flipped bit never yields another legal code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trans_req_i | input | 1 | Transition request, sampled in idle |
| trans_rma_i | input | 1 | Transition takes the RMA flash step; captured when the request is accepted |
| scrap_req_i | input | 1 | Scrap request, sampled in idle |
| esc_a_i | input | 1 | Escalation input A |
| esc_b_i | input | 1 | Escalation input B |
| step_done_i | input | 1 | Current step unit has finished |
| step_err_i | input | 1 | Current step finished with an error (valid with done) |
| step_req_o | output | 1 | One-cycle start pulse to the step unit |
| step_id_o | output | 3 | Number of the active step (state number minus 3) |
| state_o | output | 4 | Decoded state number |
| trans_ack_o | output | 1 | Post-transition reached |
| trans_err_o | output | 1 | Sticky step error flag |
| scrapped_o | output | 1 | Scrap state reached |
| escalated_o | output | 1 | Escalate state reached |

## Verification
The bench fails each checked step in turn, on both the RMA and the non-RMA path. A machine that ignored an error or followed the wrong branch would reach acknowledge after the wrong number of cycles, or would issue the wrong number of step pulses. A stalled token compare must hold without re-pulsing its request. A design that re-triggered on every waiting cycle, or moved on without done, would show extra pulses or an early state change. Escalation is raised in idle, mid-chain, in scrap and in post-transition, and it is checked to stay after the inputs drop. A scrap-versus-transition collision in idle and a single-bit upset of the state register check the priority order and the invalid-to-escalate path.

// File: rtl/lct_pkg.sv
`timescale 1ns/1ps
package lct_pkg;
  localparam int unsigned CODE_W    = 16;
  localparam int unsigned NUM_ST    = 15;
  localparam int unsigned IDX_W     = $clog2(NUM_ST);
  localparam int unsigned STEP_BASE = 3;
  localparam int unsigned NUM_STEP  = 8;
  localparam int unsigned STEP_W    = $clog2(NUM_STEP);

  typedef enum logic [IDX_W-1:0] {
    ST_RESET      = 4'd0,
    ST_IDLE       = 4'd1,
    ST_CLKMUX     = 4'd2,
    ST_CNT_INCR   = 4'd3,
    ST_CNT_PROG   = 4'd4,
    ST_TRANS_CHK  = 4'd5,
    ST_TOK_HASH   = 4'd6,
    ST_FLASH_RMA  = 4'd7,
    ST_TOK_CHK0   = 4'd8,
    ST_TOK_CHK1   = 4'd9,
    ST_TRANS_PROG = 4'd10,
    ST_POST       = 4'd11,
    ST_SCRAP      = 4'd12,
    ST_ESCALATE   = 4'd13,
    ST_INVALID    = 4'd14
  } lct_st_e;

  // Sparse codes, each of even parity: any single-bit upset is illegal.
  function automatic logic [CODE_W-1:0] st_code(lct_st_e s);
    logic [CODE_W-1:0] c;
    case (s)
      ST_RESET:      c = 16'h0F0F;
      ST_IDLE:       c = 16'h33C3;
      ST_CLKMUX:     c = 16'h5A5A;
      ST_CNT_INCR:   c = 16'h6996;
      ST_CNT_PROG:   c = 16'hA5C3;
      ST_TRANS_CHK:  c = 16'h3C0F;
      ST_TOK_HASH:   c = 16'h9A65;
      ST_FLASH_RMA:  c = 16'hC6A9;
      ST_TOK_CHK0:   c = 16'h1E78;
      ST_TOK_CHK1:   c = 16'h7281;
      ST_TRANS_PROG: c = 16'h4DB2;
      ST_POST:       c = 16'hE41B;
      ST_SCRAP:      c = 16'h8D3C;
      ST_ESCALATE:   c = 16'hF0A5;
      default:       c = 16'h2B5C;
    endcase
    return c;
  endfunction

  function automatic lct_st_e st_decode(logic [CODE_W-1:0] c);
    lct_st_e r;
    r = ST_INVALID;
    for (int i = 0; i < NUM_ST - 1; i++) begin
      if (c == st_code(lct_st_e'(IDX_W'(i)))) r = lct_st_e'(IDX_W'(i));
    end
    return r;
  endfunction

  function automatic logic is_step(lct_st_e s);
    return (s >= ST_CNT_INCR) && (s <= ST_TRANS_PROG);
  endfunction

  function automatic logic [STEP_W-1:0] step_of(lct_st_e s);
    logic [IDX_W-1:0] d;
    d = IDX_W'(s) - IDX_W'(STEP_BASE);
    return d[STEP_W-1:0];
  endfunction
endpackage

// File: rtl/lct_state_reg.sv
`timescale 1ns/1ps
module lct_state_reg
  import lct_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  lct_st_e nxt_i,
  output lct_st_e cur_o
);
  logic [CODE_W-1:0] state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= st_code(ST_RESET);
    else         state_q <= st_code(nxt_i);
  end

  assign cur_o = st_decode(state_q);

  AST_LEGAL_EVEN_PARITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_o != ST_INVALID) |-> (^state_q == 1'b0)); // R10
endmodule

// File: rtl/lct_next_state.sv
`timescale 1ns/1ps
module lct_next_state
  import lct_pkg::*;
(
  input  lct_st_e cur_i,
  input  logic    trans_req_i,
  input  logic    rma_i,
  input  logic    scrap_req_i,
  input  logic    esc_i,
  input  logic    done_i,
  input  logic    err_i,
  output lct_st_e nxt_o
);
  always_comb begin
    nxt_o = cur_i;
    case (cur_i)
      ST_RESET:  nxt_o = ST_IDLE;
      ST_IDLE: begin
        if (scrap_req_i)      nxt_o = ST_SCRAP;
        else if (trans_req_i) nxt_o = ST_CLKMUX;
      end
      ST_CLKMUX:    nxt_o = ST_CNT_INCR;
      ST_CNT_INCR:  if (done_i) nxt_o = err_i ? ST_POST : ST_CNT_PROG;
      ST_CNT_PROG:  if (done_i) nxt_o = err_i ? ST_POST : ST_TRANS_CHK;
      ST_TRANS_CHK: if (done_i) nxt_o = err_i ? ST_POST : ST_TOK_HASH;
      ST_TOK_HASH: begin
        if (done_i) begin
          if (err_i)      nxt_o = ST_POST;
          else if (rma_i) nxt_o = ST_FLASH_RMA;
          else            nxt_o = ST_TRANS_PROG;
        end
      end
      ST_FLASH_RMA:  if (done_i) nxt_o = ST_TOK_CHK0;
      ST_TOK_CHK0:   if (done_i) nxt_o = err_i ? ST_POST : ST_TOK_CHK1;
      ST_TOK_CHK1:   if (done_i) nxt_o = err_i ? ST_POST : ST_TRANS_PROG;
      ST_TRANS_PROG: if (done_i) nxt_o = ST_POST;
      ST_POST, ST_SCRAP, ST_ESCALATE: nxt_o = cur_i;
      default:       nxt_o = ST_ESCALATE;
    endcase
    if (esc_i) nxt_o = ST_ESCALATE;
  end
endmodule

// File: rtl/lct_step_ctrl.sv
`timescale 1ns/1ps
module lct_step_ctrl
  import lct_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  lct_st_e           cur_i,
  input  lct_st_e           nxt_i,
  input  logic              done_i,
  input  logic              err_i,
  input  logic              rma_i,
  output logic              step_req_o,
  output logic [STEP_W-1:0] step_id_o,
  output logic              err_o,
  output logic              rma_o
);
  logic req_q, err_q, rma_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
      err_q <= 1'b0;
      rma_q <= 1'b0;
    end else begin
      req_q <= is_step(nxt_i) && (nxt_i != cur_i);
      if (is_step(cur_i) && done_i && err_i) err_q <= 1'b1;
      if (cur_i == ST_IDLE && nxt_i == ST_CLKMUX) rma_q <= rma_i;
    end
  end

  assign step_req_o = req_q;
  assign step_id_o  = is_step(cur_i) ? step_of(cur_i) : '0;
  assign err_o      = err_q;
  assign rma_o      = rma_q;

  AST_REQ_ON_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_req_o |-> (cur_i != $past(cur_i))); // R3
  AST_REQ_IN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_req_o |-> is_step(cur_i)); // R2
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o); // R4
endmodule

// File: rtl/lct_sequencer.sv
`timescale 1ns/1ps
module lct_sequencer
  import lct_pkg::*;
(
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       trans_req_i,
  input  logic                       trans_rma_i,
  input  logic                       scrap_req_i,
  input  logic                       esc_a_i,
  input  logic                       esc_b_i,
  input  logic                       step_done_i,
  input  logic                       step_err_i,
  output logic                       step_req_o,
  output logic [lct_pkg::STEP_W-1:0] step_id_o,
  output logic [lct_pkg::IDX_W-1:0]  state_o,
  output logic                       trans_ack_o,
  output logic                       trans_err_o,
  output logic                       scrapped_o,
  output logic                       escalated_o
);
  lct_st_e cur, nxt;
  logic    esc, rma_held;

  assign esc = esc_a_i | esc_b_i;

  lct_state_reg u_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .nxt_i  (nxt),
    .cur_o  (cur)
  );

  lct_next_state u_next (
    .cur_i       (cur),
    .trans_req_i (trans_req_i),
    .rma_i       (rma_held),
    .scrap_req_i (scrap_req_i),
    .esc_i       (esc),
    .done_i      (step_done_i),
    .err_i       (step_err_i),
    .nxt_o       (nxt)
  );

  lct_step_ctrl u_step (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cur_i      (cur),
    .nxt_i      (nxt),
    .done_i     (step_done_i),
    .err_i      (step_err_i),
    .rma_i      (trans_rma_i),
    .step_req_o (step_req_o),
    .step_id_o  (step_id_o),
    .err_o      (trans_err_o),
    .rma_o      (rma_held)
  );

  assign state_o     = cur;
  assign trans_ack_o = (cur == ST_POST);
  assign scrapped_o  = (cur == ST_SCRAP);
  assign escalated_o = (cur == ST_ESCALATE);

  AST_ESC_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    esc |=> (cur == ST_ESCALATE)); // R8
  AST_ESC_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur == ST_ESCALATE) |=> (cur == ST_ESCALATE)); // R8
  AST_INVALID_ESCALATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur == ST_INVALID) |=> (cur == ST_ESCALATE)); // R9
  AST_CLKMUX_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur == ST_CLKMUX && !esc) |=> (cur == ST_CNT_INCR)); // R2
  AST_STEP_WAITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_step(cur) && !step_done_i && !esc) |=> $stable(cur)); // R3
  AST_POST_TERMINAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur == ST_POST && !esc) |=> (cur == ST_POST)); // R6
  AST_SCRAP_TERMINAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur == ST_SCRAP && !esc) |=> (cur == ST_SCRAP)); // R7
endmodule

// File: tb/test_lct_sequencer.sv
`timescale 1ns/1ps
module test_lct_sequencer;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       trans_req, trans_rma, scrap_req, esc_a, esc_b;
  logic       step_done, step_err;
  logic       step_req_o;
  logic [2:0] step_id_o;
  logic [3:0] state_o;
  logic       trans_ack_o, trans_err_o, scrapped_o, escalated_o;

  logic       fail_en, hold_en, hold_rel;
  logic [2:0] fail_id, hold_id;
  int         total = 0;
  int         bad = 0;

  always #2.5 clk = ~clk;

  lct_sequencer i_lct_sequencer (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .trans_req_i (trans_req),
    .trans_rma_i (trans_rma),
    .scrap_req_i (scrap_req),
    .esc_a_i     (esc_a),
    .esc_b_i     (esc_b),
    .step_done_i (step_done),
    .step_err_i  (step_err),
    .step_req_o  (step_req_o),
    .step_id_o   (step_id_o),
    .state_o     (state_o),
    .trans_ack_o (trans_ack_o),
    .trans_err_o (trans_err_o),
    .scrapped_o  (scrapped_o),
    .escalated_o (escalated_o)
  );

  // Stub responder: answers at once unless the held step is active.
  always_comb begin
    step_done = !(hold_en && step_id_o == hold_id) || hold_rel;
    step_err  = fail_en && (step_id_o == fail_id);
  end

  // {rma, fail_en, fail_id, exp_err, exp_edges, exp_pulses}
  localparam int NVEC = 12;
  localparam logic [13:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 3'd0, 1'b0, 4'd7,  4'd5},
    {1'b1, 1'b0, 3'd0, 1'b0, 4'd10, 4'd8},
    {1'b0, 1'b1, 3'd0, 1'b1, 4'd3,  4'd1},
    {1'b0, 1'b1, 3'd1, 1'b1, 4'd4,  4'd2},
    {1'b0, 1'b1, 3'd2, 1'b1, 4'd5,  4'd3},
    {1'b0, 1'b1, 3'd3, 1'b1, 4'd6,  4'd4},
    {1'b0, 1'b1, 3'd7, 1'b1, 4'd7,  4'd5},
    {1'b1, 1'b1, 3'd4, 1'b1, 4'd10, 4'd8},
    {1'b1, 1'b1, 3'd5, 1'b1, 4'd8,  4'd6},
    {1'b1, 1'b1, 3'd6, 1'b1, 4'd9,  4'd7},
    {1'b1, 1'b1, 3'd7, 1'b1, 4'd10, 4'd8},
    {1'b0, 1'b1, 3'd5, 1'b0, 4'd7,  4'd5}
  };

  task automatic chk(input string rq, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    trans_req = 0; trans_rma = 0; scrap_req = 0; esc_a = 0; esc_b = 0;
    fail_en = 0; fail_id = 0; hold_en = 0; hold_id = 0; hold_rel = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_state(input int s);
    for (int k = 0; k < 20 && state_o != 4'(s); k++) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset state
    rst_n = 1'b0;
    trans_req = 0; trans_rma = 0; scrap_req = 0; esc_a = 0; esc_b = 0;
    fail_en = 0; fail_id = 0; hold_en = 0; hold_id = 0; hold_rel = 0;
    repeat (2) @(negedge clk);
    chk("R1 state in reset", state_o, 0);
    chk("R1 outputs in reset",
        {step_req_o, trans_ack_o, trans_err_o, scrapped_o, escalated_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", state_o, 1);

    // Vector walk: R2 pulses, R4 error exits, R5 ordering, R6 ack
    for (int v = 0; v < NVEC; v++) begin
      int edges;
      int pulses;
      do_reset();
      trans_rma = VEC[v][13];
      fail_en   = VEC[v][12];
      fail_id   = VEC[v][11:9];
      trans_req = 1'b1;
      edges = 0;
      pulses = 0;
      while (!trans_ack_o && edges < 30) begin
        @(negedge clk);
        edges++;
        if (step_req_o) pulses++;
      end
      chk($sformatf("R5 R4 vec%0d cycles to ack", v), edges, int'(VEC[v][7:4]));
      chk($sformatf("R2 vec%0d step pulses", v), pulses, int'(VEC[v][3:0]));
      chk($sformatf("R4 R6 vec%0d error flag", v), trans_err_o, int'(VEC[v][8]));
    end

    // R3: hold in token compare 1 while done is low
    do_reset();
    hold_en = 1; hold_id = 3'd6; trans_rma = 1; trans_req = 1;
    wait_state(9);
    chk("R2 entry pulse compare 1", step_req_o, 1);
    chk("R2 step id compare 1", step_id_o, 6);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R3 holds in compare 1", state_o, 9);
      chk("R3 no repeat pulse", step_req_o, 0);
    end
    hold_rel = 1;
    @(negedge clk);
    chk("R5 compare 1 to state program", state_o, 10);
    @(negedge clk);
    chk("R6 ack after release", trans_ack_o, 1);
    chk("R6 no error after release", trans_err_o, 0);

    // R6: post-transition ignores requests, then R8 escalation
    trans_req = 1; scrap_req = 1;
    repeat (3) @(negedge clk);
    chk("R6 post terminal", state_o, 11);
    chk("R6 no step pulse in post", step_req_o, 0);
    esc_b = 1;
    @(negedge clk);
    chk("R8 post to escalate", state_o, 13);

    // R8: escalation mid-chain while token hash waits
    do_reset();
    hold_en = 1; hold_id = 3'd3; trans_req = 1;
    wait_state(6);
    chk("R2 reached token hash", state_o, 6);
    esc_b = 1;
    @(negedge clk);
    chk("R8 hash to escalate", state_o, 13);
    chk("R8 escalated flag", escalated_o, 1);
    esc_b = 0; hold_rel = 1;
    repeat (3) @(negedge clk);
    chk("R8 escalate holds", state_o, 13);

    // R8: escalation from idle on the other input
    do_reset();
    esc_a = 1;
    @(negedge clk);
    chk("R8 idle to escalate", state_o, 13);

    // R7: scrap beats transition, then stays
    do_reset();
    scrap_req = 1; trans_req = 1;
    @(negedge clk);
    chk("R7 scrap priority", state_o, 12);
    chk("R7 scrapped flag", scrapped_o, 1);
    scrap_req = 0;
    repeat (3) @(negedge clk);
    chk("R7 scrap terminal", state_o, 12);
    chk("R7 no step pulse", step_req_o, 0);
    esc_a = 1;
    @(negedge clk);
    chk("R8 scrap to escalate", state_o, 13);

    // R9 R10: single-bit upset of the idle code
    do_reset();
    force i_lct_sequencer.u_reg.state_q = 16'h33E3;
    #1;
    release i_lct_sequencer.u_reg.state_q;
    #0.5;
    chk("R9 R10 upset shows invalid", state_o, 14);
    @(negedge clk);
    chk("R9 invalid to escalate", state_o, 13);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule